// File: doc/BRIEF.md
# Coprocessor Task Trigger Dispatcher

This block chooses what a small coprocessor core runs next. Eight foreground tasks can each be requested in two ways. One is a rising edge on a peripheral interrupt line. The other is a software force command, which carries a mask of tasks. The dispatcher holds a pending flag for each task and gates the flags with a per-task enable mask. It picks the lowest-numbered ready task and issues a one-cycle start request that carries the task number and the task's start address. The address comes from a programmable start-vector register for each task.

When the core reports that a task has stopped, the next ready task is started at once. No new trigger is needed. An optional background task fills the time when no foreground task runs. A ready foreground task preempts it, which gives a single level of nesting. The core's program counter is saved at preemption so that the background task resumes where it left off. While the background task raises its critical-section input, preemption is held off.

Configuration writes take effect only while a write-protect unlock input is high. A build parameter selects a reduced-address variant. In that variant the vectors are 12-bit offsets, added to a fixed program-space base.

Top module: `cotd_dispatcher`

## Requirements
- R1: After reset, no start request is issued. Pending flags, the enable mask, the vectors and the control bits are all zero.
- R2: A trigger is recorded only on a low-to-high transition of its interrupt line, and the line is compared with its value at the previous clock edge. A line that is already high when reset is released records no trigger until it falls and rises again. The start request goes high one clock after the edge that records the trigger.
- R3: A pending task launches only while its bit in the enable mask is set (bit k covers task k+1). A pending task whose enable bit is clear stays pending and launches once the bit is set.
- R4: A software force command sets the pending flag of task k+1 for each set bit k of its mask. It has no effect unless control bit 0 (force enable) is set.
- R5: When several ready tasks are waiting, the lowest-numbered one is chosen. Its pending flag is cleared at the same clock edge that raises start_req_o. start_id_o carries the task number 1 to 8.
- R6: While a foreground task runs, no new start request is issued until core_stop_i is seen. At that stop the next ready task, if there is one, is requested in the following cycle.
- R7: With control bit 1 (background enable) set and no foreground task running or ready, the background task is requested with start_id_o = 0 and the background vector as its address. A stop pulse while the background task runs is ignored.
- R8: A ready foreground task preempts a running background task. core_pc_i is saved in the cycle the preemption is decided.
- R9: While bg_critical_i is high, a running background task is not preempted. The foreground requests stay pending.
- R10: When a foreground task that preempted the background task stops and no other task is ready, the background task is requested again with start_id_o = 0 and the saved address.
- R11: Configuration writes are accepted only while cfg_unlock_i is high. The address map is: 0 to 7 for the vectors of tasks 1 to 8, 8 for the enable mask, 9 for the control bits and 10 for the background vector. Writes made while the unlock input is low change nothing.
- R12: With REDUCED_ADDR set, only the low 12 bits of each vector are stored, and start_addr_o = PROG_BASE + offset. A resumed address is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_TASKS | Peripheral interrupt lines, bit k for task k+1 |
| cfg_unlock_i | input | 1 | Write-protect unlock |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | $clog2(N_TASKS+3) | Configuration register select |
| cfg_data_i | input | ADDR_W | Configuration write data |
| force_i | input | 1 | Software force command strobe |
| force_mask_i | input | N_TASKS | Tasks to force, bit k for task k+1 |
| core_stop_i | input | 1 | The running task has stopped |
| core_pc_i | input | ADDR_W | Core program counter, saved at preemption |
| bg_critical_i | input | 1 | Background task is in a critical section |
| start_req_o | output | 1 | One-cycle start request |
| start_id_o | output | $clog2(N_TASKS+1) | Task to start, 0 for the background task |
| start_addr_o | output | ADDR_W | Start address of that task |

## Verification
Some properties are checked on every cycle. Each foreground launch must be the lowest-numbered task that was both pending and enabled in the cycle before. No request may appear while a foreground task runs without a stop, or while a critical section holds the background task. The background task is never relaunched over itself, and the output stays quiet right after reset. Other behaviour needs the bench's stimulus sequences and its cycle-accurate model. These are edge-only capture with a line held high through reset, gating of the force command, writes dropped while locked, the saved-address resume and the reduced-address mapping.

// File: rtl/cotd_pkg.sv
package cotd_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_FG   = 2'd1,
        MODE_BG   = 2'd2,
        MODE_NEST = 2'd3
    } run_mode_e;

    localparam int CTL_FORCE_BIT = 0;
    localparam int CTL_BG_BIT    = 1;

endpackage

// File: rtl/cotd_trig_capture.sv
module cotd_trig_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic         force_i,
    input  logic [N-1:0] force_mask_i,
    input  logic         force_en_i,
    input  logic [N-1:0] clear_i,
    output logic [N-1:0] pending_o
);

    typedef struct packed {
        logic [N-1:0] line;
        logic [N-1:0] pend;
    } cap_t;

    cap_t q, d;
    logic [N-1:0] rise;
    logic [N-1:0] forced;

    always_comb begin
        rise   = irq_i & ~q.line;
        forced = (force_i && force_en_i) ? force_mask_i : '0;
        d.line = irq_i;
        d.pend = (q.pend & ~clear_i) | rise | forced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.line <= '1;
            q.pend <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending_o = q.pend;

endmodule

// File: rtl/cotd_cfg_regs.sv
module cotd_cfg_regs
    import cotd_pkg::*;
#(
    parameter int N      = 8,
    parameter int VEC_W  = 16,
    parameter int DATA_W = 16,
    parameter int CA_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      unlock_i,
    input  logic                      wr_i,
    input  logic [CA_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]         data_i,
    output logic [N-1:0][VEC_W-1:0]   vec_o,
    output logic [VEC_W-1:0]          bg_vec_o,
    output logic [N-1:0]              en_mask_o,
    output logic                      force_en_o,
    output logic                      bg_en_o
);

    typedef struct packed {
        logic [N-1:0][VEC_W-1:0] vec;
        logic [VEC_W-1:0]        bg_vec;
        logic [N-1:0]            en;
        logic                    force_en;
        logic                    bg_en;
    } cfg_t;

    cfg_t q, d;

    always_comb begin
        d = q;
        if (unlock_i && wr_i) begin
            for (int k = 0; k < N; k++) begin
                if (addr_i == CA_W'(k)) begin
                    d.vec[k] = data_i[VEC_W-1:0];
                end
            end
            if (addr_i == CA_W'(N)) begin
                d.en = data_i[N-1:0];
            end
            if (addr_i == CA_W'(N + 1)) begin
                d.force_en = data_i[CTL_FORCE_BIT];
                d.bg_en    = data_i[CTL_BG_BIT];
            end
            if (addr_i == CA_W'(N + 2)) begin
                d.bg_vec = data_i[VEC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign vec_o      = q.vec;
    assign bg_vec_o   = q.bg_vec;
    assign en_mask_o  = q.en;
    assign force_en_o = q.force_en;
    assign bg_en_o    = q.bg_en;

endmodule

// File: rtl/cotd_lowest_pick.sv
module cotd_lowest_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     onehot_o
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_chain
        assign onehot_o[k] = req_i[k] & ~seen[k];
        assign seen[k+1]   = seen[k] | req_i[k];
    end

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (onehot_o[k]) begin
                idx_o = idx_o | IDX_W'(k);
            end
        end
    end

    assign any_o = seen[N];

endmodule

// File: rtl/cotd_addr_map.sv
module cotd_addr_map #(
    parameter int                VEC_W     = 16,
    parameter int                ADDR_W    = 16,
    parameter bit                REDUCED   = 1'b0,
    parameter logic [ADDR_W-1:0] PROG_BASE = '0
) (
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] addr_o
);

    if (REDUCED) begin : g_offset
        assign addr_o = PROG_BASE + ADDR_W'(vec_i);
    end else begin : g_absolute
        assign addr_o = ADDR_W'(vec_i);
    end

endmodule

// File: rtl/cotd_dispatcher.sv
module cotd_dispatcher
    import cotd_pkg::*;
#(
    parameter int                N_TASKS      = 8,
    parameter int                ADDR_W       = 16,
    parameter bit                REDUCED_ADDR = 1'b0,
    parameter int                OFFS_W       = 12,
    parameter logic [ADDR_W-1:0] PROG_BASE    = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_TASKS-1:0]               irq_i,
    input  logic                             cfg_unlock_i,
    input  logic                             cfg_wr_i,
    input  logic [$clog2(N_TASKS+3)-1:0]     cfg_addr_i,
    input  logic [ADDR_W-1:0]                cfg_data_i,
    input  logic                             force_i,
    input  logic [N_TASKS-1:0]               force_mask_i,
    input  logic                             core_stop_i,
    input  logic [ADDR_W-1:0]                core_pc_i,
    input  logic                             bg_critical_i,
    output logic                             start_req_o,
    output logic [$clog2(N_TASKS+1)-1:0]     start_id_o,
    output logic [ADDR_W-1:0]                start_addr_o
);

    localparam int IDX_W = $clog2(N_TASKS);
    localparam int ID_W  = $clog2(N_TASKS + 1);
    localparam int CA_W  = $clog2(N_TASKS + 3);
    localparam int VEC_W = REDUCED_ADDR ? OFFS_W : ADDR_W;

    typedef struct packed {
        run_mode_e         mode;
        logic [ADDR_W-1:0] saved;
        logic              req;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
    } disp_t;

    disp_t q, d;

    logic [N_TASKS-1:0][VEC_W-1:0] vec;
    logic [VEC_W-1:0]              bg_vec;
    logic [N_TASKS-1:0]            en_mask;
    logic                          force_en;
    logic                          bg_en;
    logic [N_TASKS-1:0]            pending;
    logic [N_TASKS-1:0]            ready;
    logic [N_TASKS-1:0]            pick_onehot;
    logic [IDX_W-1:0]              pick_idx;
    logic                          any_ready;
    logic [N_TASKS-1:0]            clr;
    logic [VEC_W-1:0]              fg_vec;
    logic [ADDR_W-1:0]             fg_addr;
    logic [ADDR_W-1:0]             bg_addr;
    logic                          launch_fg;
    logic                          launch_bg;
    logic                          resume;
    run_mode_e                     cur_mode;

    cotd_cfg_regs #(
        .N      (N_TASKS),
        .VEC_W  (VEC_W),
        .DATA_W (ADDR_W),
        .CA_W   (CA_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_i   (cfg_unlock_i),
        .wr_i       (cfg_wr_i),
        .addr_i     (cfg_addr_i),
        .data_i     (cfg_data_i),
        .vec_o      (vec),
        .bg_vec_o   (bg_vec),
        .en_mask_o  (en_mask),
        .force_en_o (force_en),
        .bg_en_o    (bg_en)
    );

    cotd_trig_capture #(
        .N (N_TASKS)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq_i),
        .force_i      (force_i),
        .force_mask_i (force_mask_i),
        .force_en_i   (force_en),
        .clear_i      (clr),
        .pending_o    (pending)
    );

    assign ready = pending & en_mask;

    cotd_lowest_pick #(
        .N     (N_TASKS),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i    (ready),
        .any_o    (any_ready),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    assign fg_vec = vec[pick_idx];

    cotd_addr_map #(
        .VEC_W     (VEC_W),
        .ADDR_W    (ADDR_W),
        .REDUCED   (REDUCED_ADDR),
        .PROG_BASE (PROG_BASE)
    ) u_map_fg (
        .vec_i  (fg_vec),
        .addr_o (fg_addr)
    );

    cotd_addr_map #(
        .VEC_W     (VEC_W),
        .ADDR_W    (ADDR_W),
        .REDUCED   (REDUCED_ADDR),
        .PROG_BASE (PROG_BASE)
    ) u_map_bg (
        .vec_i  (bg_vec),
        .addr_o (bg_addr)
    );

    always_comb begin
        d         = q;
        d.req     = 1'b0;
        clr       = '0;
        launch_fg = 1'b0;
        launch_bg = 1'b0;
        resume    = 1'b0;

        unique case (q.mode)
            MODE_IDLE: begin
                if (any_ready) begin
                    launch_fg = 1'b1;
                    d.mode    = MODE_FG;
                end else if (bg_en) begin
                    launch_bg = 1'b1;
                    d.mode    = MODE_BG;
                end
            end
            MODE_FG: begin
                if (core_stop_i) begin
                    if (any_ready) begin
                        launch_fg = 1'b1;
                    end else if (bg_en) begin
                        launch_bg = 1'b1;
                        d.mode    = MODE_BG;
                    end else begin
                        d.mode = MODE_IDLE;
                    end
                end
            end
            MODE_NEST: begin
                if (core_stop_i) begin
                    if (any_ready) begin
                        launch_fg = 1'b1;
                    end else begin
                        resume = 1'b1;
                        d.mode = MODE_BG;
                    end
                end
            end
            MODE_BG: begin
                if (any_ready && !bg_critical_i) begin
                    launch_fg = 1'b1;
                    d.mode    = MODE_NEST;
                    d.saved   = core_pc_i;
                end
            end
            default: begin
                d.mode = MODE_IDLE;
            end
        endcase

        if (launch_fg) begin
            clr    = pick_onehot;
            d.req  = 1'b1;
            d.id   = ID_W'(pick_idx) + ID_W'(1);
            d.addr = fg_addr;
        end else if (launch_bg) begin
            d.req  = 1'b1;
            d.id   = '0;
            d.addr = bg_addr;
        end else if (resume) begin
            d.req  = 1'b1;
            d.id   = '0;
            d.addr = q.saved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode  <= MODE_IDLE;
            q.saved <= '0;
            q.req   <= 1'b0;
            q.id    <= '0;
            q.addr  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_mode     = q.mode;
    assign start_req_o  = q.req;
    assign start_id_o   = q.id;
    assign start_addr_o = q.addr;

endmodule

// File: rtl/cotd_dispatcher_chk.sv
module cotd_dispatcher_chk
    import cotd_pkg::*;
#(
    parameter int N    = 8,
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_req,
    input logic [ID_W-1:0] start_id,
    input logic [N-1:0]    pending,
    input logic [N-1:0]    en_mask,
    input run_mode_e       mode,
    input logic            bg_critical,
    input logic            core_stop
);

    logic [N-1:0] ready_prev;
    logic [N-1:0] en_prev;
    logic [N-1:0] below;
    logic         live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_prev <= '0;
            en_prev    <= '0;
            live_q     <= 1'b0;
        end else begin
            ready_prev <= pending & en_mask;
            en_prev    <= en_mask;
            live_q     <= 1'b1;
        end
    end

    always_comb begin
        below = (N'(1) << (start_id - ID_W'(1))) - N'(1);
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> !start_req);

    assert_launch_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_id != '0) |-> en_prev[start_id - ID_W'(1)]);

    assert_pick_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_id != '0) |->
            (ready_prev[start_id - ID_W'(1)] && ((ready_prev & below) == '0)));

    assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FG || mode == MODE_NEST) && !core_stop) |=> !start_req);

    assert_no_bg_relaunch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && start_id == '0) |-> $past(mode) != MODE_BG);

    assert_critical_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BG && bg_critical) |=> !start_req);

endmodule

bind cotd_dispatcher cotd_dispatcher_chk #(
    .N    (N_TASKS),
    .ID_W ($clog2(N_TASKS + 1))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req_o),
    .start_id    (start_id_o),
    .pending     (pending),
    .en_mask     (en_mask),
    .mode        (cur_mode),
    .bg_critical (bg_critical_i),
    .core_stop   (core_stop_i)
);

// File: tb/cotd_dispatcher_test.sv
module cotd_dispatcher_test;

    localparam logic [15:0] RBASE = 16'h8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq = 8'h04;
    logic        unlock = 1'b0;
    logic        wen = 1'b0;
    logic [3:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic        fv = 1'b0;
    logic [7:0]  fmask = '0;
    logic        stop = 1'b0;
    logic [15:0] pc = '0;
    logic        crit = 1'b0;

    logic        req, r_req;
    logic [3:0]  id, r_id;
    logic [15:0] addr, r_addr;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference state
    int          m_mode;
    logic [7:0]  m_prev, m_pend, m_en;
    logic [15:0] m_vec [8];
    logic [15:0] m_bgvec, m_saved;
    bit          m_fen, m_bgen;
    bit          e_req;
    int          e_id;
    logic [15:0] e_addr, e_raddr;
    int          seen_starts;

    always #5 clk = ~clk;

    cotd_dispatcher uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_unlock_i(unlock),
        .cfg_wr_i(wen), .cfg_addr_i(waddr), .cfg_data_i(wdata),
        .force_i(fv), .force_mask_i(fmask), .core_stop_i(stop),
        .core_pc_i(pc), .bg_critical_i(crit),
        .start_req_o(req), .start_id_o(id), .start_addr_o(addr)
    );

    cotd_dispatcher #(.REDUCED_ADDR(1'b1), .PROG_BASE(RBASE)) uut_red (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_unlock_i(unlock),
        .cfg_wr_i(wen), .cfg_addr_i(waddr), .cfg_data_i(wdata),
        .force_i(fv), .force_mask_i(fmask), .core_stop_i(stop),
        .core_pc_i(pc), .bg_critical_i(crit),
        .start_req_o(r_req), .start_id_o(r_id), .start_addr_o(r_addr)
    );

    function automatic logic [15:0] red_addr(logic [15:0] v);
        return RBASE + {4'h0, v[11:0]};
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_prev = 8'hFF; m_pend = '0; m_en = '0;
        for (int k = 0; k < 8; k++) m_vec[k] = '0;
        m_bgvec = '0; m_saved = '0; m_fen = 0; m_bgen = 0;
    endtask

    task automatic model_step();
        logic [7:0] rdy, clrm, rise;
        bit any, lf, lb, rs;
        int idx;
        rdy = m_pend & m_en;
        any = (rdy != 0);
        idx = 0;
        for (int k = 7; k >= 0; k--) if (rdy[k]) idx = k;
        lf = 0; lb = 0; rs = 0;
        case (m_mode)
            0: if (any) begin lf = 1; m_mode = 1; end
               else if (m_bgen) begin lb = 1; m_mode = 2; end
            1: if (stop) begin
                   if (any) lf = 1;
                   else if (m_bgen) begin lb = 1; m_mode = 2; end
                   else m_mode = 0;
               end
            3: if (stop) begin
                   if (any) lf = 1;
                   else begin rs = 1; m_mode = 2; end
               end
            default: if (any && !crit) begin lf = 1; m_mode = 3; m_saved = pc; end
        endcase
        e_req = lf | lb | rs;
        e_id = lf ? idx + 1 : 0;
        if (lf) begin e_addr = m_vec[idx]; e_raddr = red_addr(m_vec[idx]); end
        else if (lb) begin e_addr = m_bgvec; e_raddr = red_addr(m_bgvec); end
        else begin e_addr = m_saved; e_raddr = m_saved; end
        clrm = lf ? (8'h01 << idx) : 8'h00;
        rise = irq & ~m_prev;
        m_pend = (m_pend & ~clrm) | rise | ((fv && m_fen) ? fmask : 8'h00);
        m_prev = irq;
        if (unlock && wen) begin
            if (waddr < 8) m_vec[waddr[2:0]] = wdata;
            else if (waddr == 8) m_en = wdata[7:0];
            else if (waddr == 9) begin m_fen = wdata[0]; m_bgen = wdata[1]; end
            else if (waddr == 10) m_bgvec = wdata;
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        if (req) seen_starts++;
        check(req === e_req, tag, "start_req", req, e_req);
        check(r_req === e_req, {tag, " R12"}, "reduced start_req", r_req, e_req);
        if (e_req) begin
            check(id === 4'(e_id), tag, "start_id", id, e_id);
            check(addr === e_addr, tag, "start_addr", addr, e_addr);
            check(r_addr === e_raddr, "R12", "reduced start_addr", r_addr, e_raddr);
        end
        fv = 1'b0; stop = 1'b0; wen = 1'b0;
    endtask

    task automatic cfg_write(logic [3:0] a, logic [15:0] v, logic unl);
        unlock = unl; waddr = a; wdata = v; wen = 1'b1;
        cyc();
    endtask

    task automatic expect_start(int xid, logic [15:0] xa, logic [15:0] xra, string rq);
        check(req === 1'b1, rq, "directed start_req", req, 1);
        check(id === 4'(xid), rq, "directed start_id", id, xid);
        check(addr === xa, rq, "directed start_addr", addr, xa);
        check(r_addr === xra, "R12", "directed reduced addr", r_addr, xra);
    endtask

    task automatic expect_none(string rq);
        check(req === 1'b0 && r_req === 1'b0, rq, "no start", req, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check(req === 1'b0 && addr === 16'h0 && id === 4'h0, "R1", "reset outputs", req, 0);

        // R2: irq[2] stays high across reset release and configuration
        tag = "R2";
        seen_starts = 0;
        for (int k = 0; k < 8; k++) cfg_write(4'(k), 16'hF010 | 16'(k << 8), 1'b1);
        cfg_write(4'd8, 16'h00FF, 1'b1);
        cfg_write(4'd9, 16'h0001, 1'b1);
        cfg_write(4'd10, 16'hFC40, 1'b1);
        unlock = 1'b0;
        repeat (3) cyc();
        check(seen_starts == 0, "R2", "no launch from held line", seen_starts, 0);
        irq[2] = 1'b0; cyc();
        irq[2] = 1'b1; cyc();
        cyc();
        expect_start(3, 16'hF210, 16'h8210, "R2");
        stop = 1'b1; cyc();

        // R11: locked writes dropped
        tag = "R11";
        cfg_write(4'd0, 16'h1234, 1'b0);
        cfg_write(4'd9, 16'h0003, 1'b0);
        irq[0] = 1'b1; cyc();
        cyc();
        expect_start(1, 16'hF010, 16'h8010, "R11");
        stop = 1'b1; cyc();
        irq[0] = 1'b0;
        repeat (3) cyc();
        expect_none("R11");

        // R4: software force gated by control bit 0
        tag = "R4";
        cfg_write(4'd9, 16'h0000, 1'b1);
        unlock = 1'b0;
        fmask = 8'h28; fv = 1'b1; cyc();
        cyc(); cyc();
        expect_none("R4");
        cfg_write(4'd9, 16'h0001, 1'b1);
        unlock = 1'b0;
        fmask = 8'h28; fv = 1'b1; cyc();
        cyc();
        expect_start(4, 16'hF310, 16'h8310, "R4");
        tag = "R6";
        cyc();
        expect_none("R6");
        stop = 1'b1; cyc();
        expect_start(6, 16'hF510, 16'h8510, "R6");
        stop = 1'b1; cyc();

        // R3: enable mask gating
        tag = "R3";
        cfg_write(4'd8, 16'h00FD, 1'b1);
        unlock = 1'b0;
        irq[1] = 1'b1; cyc();
        cyc(); cyc();
        expect_none("R3");
        cfg_write(4'd8, 16'h00FF, 1'b1);
        unlock = 1'b0;
        cyc();
        expect_start(2, 16'hF110, 16'h8110, "R3");
        stop = 1'b1; cyc();

        // R5: simultaneous triggers, lowest first
        tag = "R5";
        irq = irq | 8'h90; cyc();
        cyc();
        expect_start(5, 16'hF410, 16'h8410, "R5");
        stop = 1'b1; cyc();
        expect_start(8, 16'hF710, 16'h8710, "R5");
        stop = 1'b1; cyc();

        // R7: background launch when idle
        tag = "R7";
        cfg_write(4'd9, 16'h0003, 1'b1);
        unlock = 1'b0;
        cyc();
        expect_start(0, 16'hFC40, 16'h8C40, "R7");
        stop = 1'b1; cyc();
        expect_none("R7");

        // R9: critical section holds off preemption
        tag = "R9";
        crit = 1'b1; pc = 16'h0ABC;
        irq[3] = 1'b1; cyc();
        cyc(); cyc();
        expect_none("R9");
        tag = "R8";
        crit = 1'b0; cyc();
        expect_start(4, 16'hF310, 16'h8310, "R8");
        pc = 16'h1111;

        // R10: resume at saved address
        tag = "R10";
        stop = 1'b1; cyc();
        expect_start(0, 16'h0ABC, 16'h0ABC, "R10");

        // mixed random traffic against the model
        tag = "R6 random";
        for (int n = 0; n < 3000; n++) begin
            irq   = irq ^ 8'($urandom & $urandom & $urandom);
            stop  = ($urandom % 5) == 0;
            crit  = ($urandom % 4) == 0;
            pc    = 16'($urandom);
            fv    = ($urandom % 10) == 0;
            fmask = 8'($urandom);
            if (($urandom % 25) == 0) begin
                wen = 1'b1; unlock = 1'($urandom % 2);
                waddr = 4'($urandom % 11); wdata = 16'($urandom);
            end
            cyc();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule